// File: doc/BRIEF.md
# Serial Debug Command Bridge

This block turns a stream of bytes from a serial receiver into transfers on a simple 32-bit internal bus. It acts as that bus's master, and it sends results back as bytes to a serial transmitter. A host opens each command with a control byte. The control byte carries the direction and a word count. A big-endian start address follows. For a write, the data words follow the address. The bridge then runs one bus transfer per word and steps the address by four each time.

The bridge can also report status. When a configuration input allows it, a status byte follows every transfer. That byte holds the current debug-mode flag and the 2-bit bus response. A separate pulse marks entry into debug mode. It queues a one-byte notification, and the bridge sends it only between commands. Both byte ports use valid/ready handshakes. The UART bit timing and the baud generator sit outside this block.

Top module: `dbg_link_bridge`

## Requirements
- R1: A control byte with bits 7:6 equal to 2'b11 starts a write and 2'b10 starts a read; bits 5:0 hold the word count minus one, so one command moves 1 to 64 words.
- R2: A control byte whose bit 7 is 0 is dropped: no bus transfer and no output byte result, and the bridge keeps accepting bytes.
- R3: The start address follows the control byte as four bytes, most significant byte first; write data words follow the address as four bytes each, most significant byte first.
- R4: Each word is one bus transfer: `bus_req` stays high with stable address and direction until the cycle `bus_ack` is high, and it drops the cycle after; `bus_wr` is 1 for writes and 0 for reads; no byte is taken or sent while a transfer is open.
- R5: The address of each following word in a burst is the previous address plus 4, wrapping modulo 2^32.
- R6: A read returns each word's `bus_rdata` as four bytes, most significant byte first.
- R7: With `resp_en` high, one status byte {5'b00000, dbg_mode, bus_resp} is sent after every transfer; for a read it follows that word's four data bytes.
- R8: With `resp_en` low, a write sends no byte and a read sends only its data bytes.
- R9: A `dbg_enter` pulse while `resp_en` is high queues the byte {5'b00000, dbg_mode, 2'b00}. The byte is sent only when no command is in progress, ahead of the next control byte. While it is pending between commands, `rx_ready` is low. With `resp_en` low the pulse has no effect.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_data` holds its value and no byte is lost.
- R11: During and after synchronous reset, `bus_req` and `tx_valid` are low and `rx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Byte from the serial receiver |
| rx_valid | input | 1 | rx_data holds a byte |
| rx_ready | output | 1 | Bridge takes the byte this cycle |
| tx_data | output | 8 | Byte toward the serial transmitter |
| tx_valid | output | 1 | tx_data holds a byte |
| tx_ready | input | 1 | Transmitter takes the byte this cycle |
| bus_req | output | 1 | Transfer request |
| bus_wr | output | 1 | 1 for write, 0 for read |
| bus_addr | output | 32 | Transfer address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Transfer done |
| bus_resp | input | 2 | Bus response code, valid with bus_ack |
| resp_en | input | 1 | Enables status bytes |
| dbg_mode | input | 1 | Current debug-mode flag |
| dbg_enter | input | 1 | One-cycle pulse on entry into debug mode |

## Verification
The bench builds the bridge with its default 32-bit word and 6-bit length field. This lets it issue the full 64-word burst and walk an address burst across the top of the 32-bit space into zero. The bus responder varies its acknowledge delay, and the transmitter side stalls in a fixed pattern. Together these reach the hold paths on both sides. The bench also sends notification pulses in three situations: in the middle of a burst, while idle with the transmitter blocked, and with status bytes disabled.

// File: rtl/dbg_link_pkg.sv
package dbg_link_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WDATA,
        ST_BUS,
        ST_TX
    } link_state_e;

    typedef struct packed {
        logic       is_cmd;
        logic       is_write;
        logic [5:0] count_m1;
    } ctrl_byte_t;

    function automatic ctrl_byte_t decode_ctrl(input logic [7:0] b);
        ctrl_byte_t c;
        c.is_cmd   = b[7];
        c.is_write = b[6];
        c.count_m1 = b[5:0];
        return c;
    endfunction

    function automatic logic [7:0] status_byte(input logic mode, input logic [1:0] rsp);
        return {5'b00000, mode, rsp};
    endfunction

endpackage

// File: rtl/dbg_link_gather.sv
module dbg_link_gather #(
    parameter int NBYTES = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                take,
    input  logic [7:0]          byte_in,
    output logic [NBYTES*8-1:0] word_nxt,
    output logic                last
);
    localparam int CW = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    logic [CW-1:0]       cnt;
    logic [NBYTES*8-1:0] acc;

    assign word_nxt = {acc[NBYTES*8-9:0], byte_in};
    assign last     = (cnt == CW'(NBYTES - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
            acc <= '0;
        end else if (take) begin
            acc <= word_nxt;
            cnt <= last ? '0 : cnt + CW'(1);
        end
    end
endmodule

// File: rtl/dbg_link_emit.sv
module dbg_link_emit #(
    parameter int NBYTES = 5,
    localparam int CW = $clog2(NBYTES + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [NBYTES*8-1:0] load_word,
    input  logic [CW-1:0]       load_cnt,
    input  logic                tx_ready,
    output logic [7:0]          tx_data,
    output logic                tx_valid
);
    logic [NBYTES*8-1:0] sh;
    logic [CW-1:0]       left;

    assign tx_valid = (left != '0);
    assign tx_data  = sh[NBYTES*8-1 -: 8];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            left <= '0;
        end else if (load) begin
            sh   <= load_word;
            left <= load_cnt;
        end else if (tx_valid && tx_ready) begin
            sh   <= {sh[NBYTES*8-9:0], 8'h00};
            left <= left - CW'(1);
        end
    end
endmodule

// File: rtl/dbg_link_bridge.sv
module dbg_link_bridge
    import dbg_link_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              bus_req,
    output logic              bus_wr,
    output logic [WORD_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    input  logic [WORD_W-1:0] bus_rdata,
    input  logic              bus_ack,
    input  logic [1:0]        bus_resp,
    input  logic              resp_en,
    input  logic              dbg_mode,
    input  logic              dbg_enter
);
    localparam int WB  = WORD_W / 8;
    localparam int EB  = WB + 1;
    localparam int ECW = $clog2(EB + 1);

    link_state_e      state;
    ctrl_byte_t       ctrl;
    logic             op_wr;
    logic             in_cmd;
    logic             note_pend;
    logic [LEN_W-1:0] left;
    logic [WORD_W-1:0] addr, wdata;

    logic              take, g_last;
    logic [WORD_W-1:0] g_word;
    logic              e_load;
    logic [EB*8-1:0]   e_word;
    logic [ECW-1:0]    e_cnt;

    assign ctrl     = decode_ctrl(rx_data);
    assign rx_ready = ((state == ST_IDLE) && !note_pend) ||
                      (state == ST_ADDR) || (state == ST_WDATA);
    assign take     = rx_valid && rx_ready;

    assign bus_req   = (state == ST_BUS);
    assign bus_wr    = op_wr;
    assign bus_addr  = addr;
    assign bus_wdata = wdata;

    dbg_link_gather #(.NBYTES(WB)) gather_i (
        .clk      (clk),
        .rst      (rst),
        .clr      (state == ST_IDLE),
        .take     (take && ((state == ST_ADDR) || (state == ST_WDATA))),
        .byte_in  (rx_data),
        .word_nxt (g_word),
        .last     (g_last)
    );

    always_comb begin
        e_load = 1'b0;
        e_word = '0;
        e_cnt  = '0;
        if (state == ST_IDLE && note_pend) begin
            e_load = 1'b1;
            e_word = {status_byte(dbg_mode, 2'b00), {WORD_W{1'b0}}};
            e_cnt  = ECW'(1);
        end else if (state == ST_BUS && bus_ack) begin
            e_load = 1'b1;
            if (op_wr) begin
                e_word = {status_byte(dbg_mode, bus_resp), {WORD_W{1'b0}}};
                e_cnt  = resp_en ? ECW'(1) : ECW'(0);
            end else begin
                e_word = {bus_rdata, status_byte(dbg_mode, bus_resp)};
                e_cnt  = resp_en ? ECW'(EB) : ECW'(WB);
            end
        end
    end

    dbg_link_emit #(.NBYTES(EB)) emit_i (
        .clk       (clk),
        .rst       (rst),
        .load      (e_load),
        .load_word (e_word),
        .load_cnt  (e_cnt),
        .tx_ready  (tx_ready),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            op_wr     <= 1'b0;
            in_cmd    <= 1'b0;
            note_pend <= 1'b0;
            left      <= '0;
            addr      <= '0;
            wdata     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (note_pend) begin
                        note_pend <= 1'b0;
                        in_cmd    <= 1'b0;
                        state     <= ST_TX;
                    end else if (take && ctrl.is_cmd) begin
                        op_wr  <= ctrl.is_write;
                        left   <= ctrl.count_m1[LEN_W-1:0];
                        in_cmd <= 1'b1;
                        state  <= ST_ADDR;
                    end
                end
                ST_ADDR: if (take && g_last) begin
                    addr  <= g_word;
                    state <= op_wr ? ST_WDATA : ST_BUS;
                end
                ST_WDATA: if (take && g_last) begin
                    wdata <= g_word;
                    state <= ST_BUS;
                end
                ST_BUS: if (bus_ack) state <= ST_TX;
                ST_TX: if (!tx_valid) begin
                    if (!in_cmd || left == '0) begin
                        in_cmd <= 1'b0;
                        state  <= ST_IDLE;
                    end else begin
                        left  <= left - LEN_W'(1);
                        addr  <= addr + WORD_W'(4);
                        state <= op_wr ? ST_WDATA : ST_BUS;
                    end
                end
                default: state <= ST_IDLE;
            endcase
            if (dbg_enter && resp_en) note_pend <= 1'b1;
        end
    end
endmodule

// File: rtl/dbg_link_bridge_chk.sv
module dbg_link_bridge_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [7:0]        rx_data,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic [7:0]        tx_data,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              bus_req,
    input logic              bus_wr,
    input logic [WORD_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [WORD_W-1:0] bus_rdata,
    input logic              bus_ack,
    input logic [1:0]        bus_resp,
    input logic              resp_en,
    input logic              dbg_mode,
    input logic              dbg_enter
);
    // R4: request held with stable address and direction until acknowledged
    assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_wr)));

    // R4: one acknowledge closes the transfer
    assert_req_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_ack) |=> !bus_req);

    // R4: no byte traffic while a transfer is open
    assert_bus_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> (!rx_ready && !tx_valid));

    // R10: a stalled byte is held
    assert_tx_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R9: output bytes never interleave with input parsing
    assert_tx_excl_R9: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !rx_ready);

    // R11: reset leaves the bridge idle
    assert_reset_idle_R11: assert property (@(posedge clk)
        rst |=> (!bus_req && !tx_valid && rx_ready));
endmodule

bind dbg_link_bridge dbg_link_bridge_chk #(.WORD_W(WORD_W)) chk_i (.*);

// File: tb/dbg_link_bridge_tb.sv
`timescale 1ns/1ps
module dbg_link_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic        bus_req, bus_wr;
    logic [31:0] bus_addr, bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;
    logic [1:0]  bus_resp = '0;
    logic        resp_en = 1'b0;
    logic        dbg_mode = 1'b0;
    logic        dbg_enter = 1'b0;

    always #4 clk = ~clk;

    dbg_link_bridge dut_i (.*);

    typedef struct { logic wr; logic [31:0] a; logic [31:0] d; } bus_exp_t;
    logic [7:0] exp_tx[$];
    bus_exp_t   exp_bus[$];
    int tests = 0, fails = 0, cyc = 0, dly = 0, nacks = 0;
    bit stall_mode = 0, hold_tx = 0, done = 0;
    logic       prev_hold;
    logic [7:0] prev_byte;

    function automatic logic [31:0] wgen(input logic [31:0] a);
        return (a * 32'd3) ^ 32'h1357_9BDF;
    endfunction
    function automatic logic [31:0] rgen(input logic [31:0] a);
        return ~a ^ 32'h0F0F_1234;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // bus responder, transmitter and per-clock comparison against the model
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            finish_run();
        end
        if (!rst) begin
            // R10: stalled byte unchanged
            if (prev_hold) chk(tx_valid && tx_data == prev_byte, "R10", {24'h0, tx_data}, {24'h0, prev_byte});
            tx_ready = hold_tx ? 1'b0 : (stall_mode ? (cyc % 3 == 0) : 1'b1);
            prev_hold = tx_valid && !tx_ready;
            prev_byte = tx_data;
            if (tx_valid && tx_ready) begin
                if (exp_tx.size() == 0) chk(0, "R2 unexpected byte", {24'h0, tx_data}, 0);
                else begin
                    logic [7:0] e;
                    e = exp_tx.pop_front();
                    chk(tx_data == e, "R6/R7 byte", {24'h0, tx_data}, {24'h0, e});
                end
            end
            if (bus_ack) bus_ack = 1'b0;
            else if (bus_req) begin
                if (dly == 0) begin
                    if (exp_bus.size() == 0) chk(0, "R2 unexpected transfer", bus_addr, 0);
                    else begin
                        bus_exp_t e;
                        e = exp_bus.pop_front();
                        chk(bus_wr == e.wr && bus_addr == e.a, "R5 addr/dir", bus_addr, e.a);
                        if (e.wr) chk(bus_wdata == e.d, "R3 wdata", bus_wdata, e.d);
                    end
                    bus_ack   = 1'b1;
                    bus_rdata = rgen(bus_addr);
                    bus_resp  = bus_addr[5:4];
                    nacks++;
                    dly = nacks % 3;
                end else dly--;
            end
        end else prev_hold = 1'b0;
    end

    task automatic send(input logic [7:0] b);
        rx_data  = b;
        rx_valid = 1'b1;
        forever begin
            if (rx_ready) begin @(negedge clk); break; end
            @(negedge clk);
        end
        rx_valid = 1'b0;
    endtask

    task automatic send_word(input logic [31:0] w);
        for (int i = 3; i >= 0; i--) send(w[i*8 +: 8]);
    endtask

    task automatic drain();
        while (exp_tx.size() != 0 || exp_bus.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    // R1 R3 R5 R7 R8: write burst with model
    task automatic do_write(input logic [31:0] a0, input int n);
        for (int i = 0; i < n; i++) begin
            logic [31:0] a;
            a = a0 + 32'(4 * i);
            exp_bus.push_back('{1'b1, a, wgen(a)});
            if (resp_en) exp_tx.push_back({5'b0, dbg_mode, a[5:4]});
        end
        send({2'b11, 6'(n - 1)});
        send_word(a0);
        for (int i = 0; i < n; i++) send_word(wgen(a0 + 32'(4 * i)));
    endtask

    // R1 R6 R7 R8: read burst with model
    task automatic do_read(input logic [31:0] a0, input int n, input bit start_only);
        for (int i = 0; i < n; i++) begin
            logic [31:0] a, d;
            a = a0 + 32'(4 * i);
            d = rgen(a);
            exp_bus.push_back('{1'b0, a, 32'h0});
            for (int k = 3; k >= 0; k--) exp_tx.push_back(d[k*8 +: 8]);
            if (resp_en) exp_tx.push_back({5'b0, dbg_mode, a[5:4]});
        end
        send({2'b10, 6'(n - 1)});
        send_word(a0);
        if (!start_only) drain();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11
        chk(!bus_req && !tx_valid && rx_ready, "R11 reset", {29'h0, bus_req, tx_valid, rx_ready}, 32'h1);

        resp_en = 1'b1;
        do_write(32'h1000_0010, 3); drain();                 // R1 R3 R4 R5 R7
        resp_en = 1'b0;
        do_write(32'h1000_0040, 1); drain();                 // R8 write silent
        do_read(32'h2000_0000, 2, 0);                        // R6 R8
        resp_en = 1'b1; stall_mode = 1;
        do_read(32'h2000_0030, 3, 0);                        // R7 R10
        do_write(32'hFFFF_FFFC, 2); drain();                 // R5 wrap
        do_read(32'hFFFF_FFF8, 3, 0);                        // R5 wrap on read
        stall_mode = 0;

        // R2: non-command control bytes are dropped
        send(8'h3F); send(8'h7F); send(8'h00);
        repeat (20) @(negedge clk);
        chk(rx_ready && !bus_req && !tx_valid, "R2 idle", {29'h0, rx_ready, bus_req, tx_valid}, 32'h4);
        do_write(32'h0000_0100, 1); drain();                 // R2 still accepts commands

        do_read(32'h3000_0000, 64, 0);                       // R1 longest burst

        // R9: pulse mid-burst, byte follows the burst
        dbg_mode = 1'b1; stall_mode = 1;
        do_read(32'h4000_0000, 4, 1);
        exp_tx.push_back(8'h04);
        dbg_enter = 1'b1; @(negedge clk); dbg_enter = 1'b0;
        drain();
        stall_mode = 0;

        // R9: pending notification blocks new bytes while idle
        hold_tx = 1;
        exp_tx.push_back(8'h04);
        dbg_enter = 1'b1; @(negedge clk); dbg_enter = 1'b0;
        repeat (3) @(negedge clk);
        chk(!rx_ready && tx_valid && tx_data == 8'h04, "R9 pending", {23'h0, rx_ready, tx_valid, tx_data}, 32'h104);
        hold_tx = 0;
        drain();

        // R9: no notification with status bytes disabled
        resp_en = 1'b0;
        dbg_enter = 1'b1; @(negedge clk); dbg_enter = 1'b0;
        repeat (10) @(negedge clk);
        chk(!tx_valid && rx_ready, "R9 disabled", {30'h0, tx_valid, rx_ready}, 32'h1);
        do_read(32'h5000_0010, 1, 0);

        chk(exp_tx.size() == 0 && exp_bus.size() == 0, "R4 all traffic seen",
            32'(exp_tx.size() + exp_bus.size()), 0);
        done = 1;
        finish_run();
    end
endmodule